// File: doc/BRIEF.md
# Debug Pin Completion Acknowledge Generator

This block sits on the target side of a single-wire debug link. When the host sends a command that the CPU has to carry out, the serial receiver strobes the end of that command. The block then waits for the CPU bus side to report completion. It answers the host with a timed low pulse on the shared pin, followed by a short active-high drive that speeds up the rising edge. After that it releases the pin to high impedance. The host needs no accurate timing of its own: it simply watches for the pulse.

All timing is counted in serial clock cycles. Each serial cycle is eight cycles of the fast system clock, and the block generates this serial clock enable itself. The pulse is never sent before a minimum distance after the command end. There is no upper limit on the wait for completion. If the CPU enters a wait or stop mode before it has carried out the command, the acknowledge is dropped and the block returns to idle. A one-cycle done strobe tells the serial transmitter when the pin has been released, so that read data or a new command may follow. A command end that arrives while an acknowledge is still owed is ignored and flagged.

Top module: `dbg_ack_gen`

## Requirements
- R1: `ser_tick_o` is high for one system clock in every 8. Its phase restarts when a command is accepted, so the first tick appears in the 8th cycle after the accepting edge.
- R2: A `cmd_end_i` strobe in idle is accepted. If completion arrives before the minimum has elapsed, `pin_oe_o` rises exactly 256 system clocks (32 serial cycles) after the edge that sampled the strobe.
- R3: If completion arrives after the minimum, the pulse starts in the cycle right after the edge that samples `cpu_done_i`. The pulse never starts earlier than 256 clocks after acceptance.
- R4: In the low phase, `pin_oe_o`=1 and `pin_do_o`=0 for exactly 128 system clocks (16 serial cycles).
- R5: The low phase is followed directly by the speedup phase, with `pin_oe_o`=1 and `pin_do_o`=1 for 8 system clocks (one serial cycle). After that `pin_oe_o`=0 and `pin_do_o`=0.
- R6: `ack_done_o` is high for exactly one clock, in the first cycle in which the pin is released.
- R7: If `lp_enter_i` is high while completion is still outstanding, the block sends no pulse and returns to idle. The next command is then accepted without an error.
- R8: Once a completion has been latched and the block is only waiting out the minimum, `lp_enter_i` has no effect and the pulse follows R2 timing.
- R9: If `cpu_done_i` and `lp_enter_i` arrive in the same cycle while completion is outstanding, completion wins and the pulse is sent.
- R10: A `cmd_end_i` that arrives while an acknowledge is pending or being driven is ignored, and the timing of that acknowledge does not change. `overlap_err_o` is high for one clock in the cycle after the strobe.
- R11: A `cpu_done_i` while idle is ignored. No pulse follows, and it does not count as completion for a later command.
- R12: Reset is asynchronous and active low. During and after reset, `pin_oe_o`, `pin_do_o`, `ack_done_o` and `overlap_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_end_i | input | 1 | Command end strobe from the serial receiver |
| cpu_done_i | input | 1 | CPU completion strobe for the pending command |
| lp_enter_i | input | 1 | CPU entering wait or stop mode |
| ser_tick_o | output | 1 | Serial clock enable, one clock in eight |
| pin_oe_o | output | 1 | Pin output enable |
| pin_do_o | output | 1 | Pin output data when enabled |
| ack_done_o | output | 1 | One-clock strobe when the pin is released |
| overlap_err_o | output | 1 | One-clock flag for an ignored overlapping command end |

## Verification
Completion and low-power entry can both reach the state machine in the same clock while a command is still outstanding. The bench raises both strobes on one clock edge, well after the minimum has elapsed. It expects the low pulse in the very next cycle, so a design that cancels would show no pulse and fail the scoreboard. A related case is low-power entry after completion has been latched but before the minimum has expired. There the bench expects the pulse at exactly 256 clocks after acceptance.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PENDING  = 3'd1,
        ST_WAIT_MIN = 3'd2,
        ST_ACK_LOW  = 3'd3,
        ST_SPEEDUP  = 3'd4
    } ack_state_e;

    typedef struct packed {
        ack_state_e state;
        logic       done;
        logic       err;
    } ack_regs_t;

endpackage

// File: rtl/dbg_ack_tick_div.sv
// Serial clock enable: one pulse every DIV system clocks, phase restartable.
module dbg_ack_tick_div #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic resync_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        if (resync_i || phase_q == LAST) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign tick_o = (phase_q == LAST);

endmodule

// File: rtl/dbg_ack_tick_cnt.sv
// Counts serial ticks up to a limit and saturates there.
module dbg_ack_tick_cnt #(
    parameter int unsigned MAXV = 32,
    localparam int unsigned CW  = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o,
    output logic          reached_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && cnt_q != limit_i) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // expire: the tick in this cycle completes the interval
    assign expire_o  = tick_i && (cnt_q == limit_i - CW'(1));
    assign reached_o = (cnt_q == limit_i);

endmodule

// File: rtl/dbg_ack_gen.sv
// Acknowledge pulse generator for a single-wire debug pin.
module dbg_ack_gen #(
    parameter int unsigned DIV     = 8,
    parameter int unsigned MIN_GAP = 32,
    parameter int unsigned LOW_LEN = 16,
    parameter int unsigned SPD_LEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_end_i,
    input  logic cpu_done_i,
    input  logic lp_enter_i,
    output logic ser_tick_o,
    output logic pin_oe_o,
    output logic pin_do_o,
    output logic ack_done_o,
    output logic overlap_err_o
);
    import dbg_ack_pkg::*;

    localparam int unsigned MAX_AB = (MIN_GAP > LOW_LEN) ? MIN_GAP : LOW_LEN;
    localparam int unsigned MAXV   = (MAX_AB > SPD_LEN) ? MAX_AB : SPD_LEN;
    localparam int unsigned CW     = $clog2(MAXV + 1);

    ack_regs_t     r_d, r_q;
    logic          tick;
    logic          restart;
    logic          expire;
    logic          reached;
    logic          min_ok;
    logic [CW-1:0] limit;

    dbg_ack_tick_div #(.DIV(DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .resync_i (restart),
        .tick_o   (tick)
    );

    dbg_ack_tick_cnt #(.MAXV(MAXV)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (restart),
        .tick_i    (tick),
        .limit_i   (limit),
        .expire_o  (expire),
        .reached_o (reached)
    );

    // interval length depends on the phase being timed
    always_comb begin
        case (r_q.state)
            ST_ACK_LOW: limit = CW'(LOW_LEN);
            ST_SPEEDUP: limit = CW'(SPD_LEN);
            default:    limit = CW'(MIN_GAP);
        endcase
    end

    assign min_ok = expire || reached;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        restart  = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (cmd_end_i) begin
                    r_d.state = ST_PENDING;
                    restart   = 1'b1;
                end
            end
            ST_PENDING: begin
                // completion beats a simultaneous low-power entry
                if (cpu_done_i) begin
                    if (min_ok) begin
                        r_d.state = ST_ACK_LOW;
                        restart   = 1'b1;
                    end else begin
                        r_d.state = ST_WAIT_MIN;
                    end
                end else if (lp_enter_i) begin
                    r_d.state = ST_IDLE;
                end
            end
            ST_WAIT_MIN: begin
                if (min_ok) begin
                    r_d.state = ST_ACK_LOW;
                    restart   = 1'b1;
                end
            end
            ST_ACK_LOW: begin
                if (expire) begin
                    r_d.state = ST_SPEEDUP;
                    restart   = 1'b1;
                end
            end
            ST_SPEEDUP: begin
                if (expire) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (cmd_end_i && r_q.state != ST_IDLE) begin
            r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ser_tick_o    = tick;
    assign pin_oe_o      = (r_q.state == ST_ACK_LOW) || (r_q.state == ST_SPEEDUP);
    assign pin_do_o      = (r_q.state == ST_SPEEDUP);
    assign ack_done_o    = r_q.done;
    assign overlap_err_o = r_q.err;

endmodule

// File: rtl/dbg_ack_chk.sv
// Protocol checker for dbg_ack_gen, attached by bind.
module dbg_ack_chk
    import dbg_ack_pkg::*;
#(
    parameter int unsigned DIV     = 8,
    parameter int unsigned MIN_GAP = 32,
    parameter int unsigned LOW_LEN = 16,
    parameter int unsigned SPD_LEN = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_end_i,
    input logic       cpu_done_i,
    input logic       lp_enter_i,
    input logic       ser_tick_o,
    input logic       pin_oe_o,
    input logic       pin_do_o,
    input logic       ack_done_o,
    input logic       overlap_err_o,
    input ack_state_e state_i
);
    localparam int unsigned GAP_MAX = MIN_GAP * DIV;
    localparam int unsigned LOW_CLK = LOW_LEN * DIV;
    localparam int unsigned SPD_CLK = SPD_LEN * DIV;
    localparam int unsigned GW      = $clog2(GAP_MAX + 1);
    localparam int unsigned LW      = $clog2(LOW_CLK + 1);
    localparam int unsigned SW      = $clog2(SPD_CLK + 1);

    logic [GW-1:0] gap_q;
    logic [LW-1:0] low_run_q;
    logic [SW-1:0] spd_run_q;
    logic          in_low, in_spd;

    assign in_low = pin_oe_o && !pin_do_o;
    assign in_spd = pin_oe_o && pin_do_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= '0;
            low_run_q <= '0;
            spd_run_q <= '0;
        end else begin
            if (cmd_end_i && state_i == ST_IDLE) begin
                gap_q <= '0;
            end else if (gap_q != GW'(GAP_MAX)) begin
                gap_q <= gap_q + GW'(1);
            end
            if (!in_low) begin
                low_run_q <= '0;
            end else if (low_run_q != LW'(LOW_CLK)) begin
                low_run_q <= low_run_q + LW'(1);
            end
            if (!in_spd) begin
                spd_run_q <= '0;
            end else if (spd_run_q != SW'(SPD_CLK)) begin
                spd_run_q <= spd_run_q + SW'(1);
            end
        end
    end

    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ser_tick_o |=> !ser_tick_o);

    p_min_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_oe_o) |-> gap_q == GW'(GAP_MAX));

    p_low_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run_q != '0 && !in_low) |-> low_run_q == LW'(LOW_CLK));

    p_low_then_spd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_low |=> pin_oe_o);

    p_spd_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_run_q != '0 && !in_spd) |-> spd_run_q == SW'(SPD_CLK) && !pin_oe_o);

    p_done_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_oe_o) |-> ack_done_o);

    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_PENDING && lp_enter_i && !cpu_done_i) |=> (state_i == ST_IDLE && !pin_oe_o));

    p_overlap_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end_i && state_i != ST_IDLE) |=> overlap_err_o);

    p_err_only_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overlap_err_o |-> $past(state_i) != ST_IDLE);

endmodule

bind dbg_ack_gen dbg_ack_chk #(
    .DIV(DIV), .MIN_GAP(MIN_GAP), .LOW_LEN(LOW_LEN), .SPD_LEN(SPD_LEN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_end_i     (cmd_end_i),
    .cpu_done_i    (cpu_done_i),
    .lp_enter_i    (lp_enter_i),
    .ser_tick_o    (ser_tick_o),
    .pin_oe_o      (pin_oe_o),
    .pin_do_o      (pin_do_o),
    .ack_done_o    (ack_done_o),
    .overlap_err_o (overlap_err_o),
    .state_i       (r_q.state)
);

// File: tb/dbg_ack_gen_tb_top.sv
module dbg_ack_gen_tb_top;

    localparam longint MINC = 256;
    localparam longint LOWC = 128;
    localparam longint SPDC = 8;

    localparam int EV_LOW  = 1;
    localparam int EV_SPD  = 2;
    localparam int EV_REL  = 3;
    localparam int EV_DONE = 4;
    localparam int EV_ERR  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_end = 1'b0;
    logic cpu_done = 1'b0;
    logic lp = 1'b0;
    logic ser_tick, pin_oe, pin_do, ack_done, ovl_err;

    longint cyc = 0;
    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    int     q_kind[$];
    longint q_cyc[$];
    string  q_req[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbg_ack_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_end_i     (cmd_end),
        .cpu_done_i    (cpu_done),
        .lp_enter_i    (lp),
        .ser_tick_o    (ser_tick),
        .pin_oe_o      (pin_oe),
        .pin_do_o      (pin_do),
        .ack_done_o    (ack_done),
        .overlap_err_o (ovl_err)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: %s actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(int k, longint c, string req);
        q_kind.push_back(k);
        q_cyc.push_back(c);
        q_req.push_back(req);
    endtask

    // full acknowledge beginning with the low phase at cycle s
    task automatic expect_ack(longint s, string req);
        expect_ev(EV_LOW, s, req);
        expect_ev(EV_SPD, s + LOWC, "R5");
        expect_ev(EV_REL, s + LOWC + SPDC, "R5");
        expect_ev(EV_DONE, s + LOWC + SPDC, "R6");
    endtask

    // called at a falling edge; strobe sampled by the next rising edge
    task automatic strobe(int which);
        case (which)
            0: cmd_end = 1'b1;
            1: cpu_done = 1'b1;
            2: lp = 1'b1;
            default: begin cpu_done = 1'b1; lp = 1'b1; end
        endcase
        @(negedge clk);
        cmd_end = 1'b0;
        cpu_done = 1'b0;
        lp = 1'b0;
    endtask

    task automatic wait_until(longint c);
        while (cyc < c) @(negedge clk);
    endtask

    // monitor: pops matching expectations as events appear
    task automatic observe(int k);
        int idx = -1;
        foreach (q_kind[i]) begin
            if (idx < 0 && q_kind[i] == k) idx = i;
        end
        if (idx < 0) begin
            check(1'b0, "R10", $sformatf("unexpected event kind %0d", k), cyc, -1);
        end else begin
            check(q_cyc[idx] == cyc, q_req[idx], $sformatf("event kind %0d cycle", k), cyc, q_cyc[idx]);
            q_kind.delete(idx);
            q_cyc.delete(idx);
            q_req.delete(idx);
        end
    endtask

    logic p_oe = 1'b0;
    logic p_do = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (pin_oe && !pin_do && !p_oe) observe(EV_LOW);
            if (pin_oe && pin_do && !(p_oe && p_do)) observe(EV_SPD);
            if (!pin_oe && p_oe) observe(EV_REL);
            if (ack_done) observe(EV_DONE);
            if (ovl_err) observe(EV_ERR);
        end
        p_oe = pin_oe;
        p_do = pin_do;
    end

    task automatic summary();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R12", "watchdog expired", cyc, 0);
        summary();
    end

    initial begin
        longint t0;
        longint t1;
        // R12: reset state
        repeat (3) @(negedge clk);
        check({pin_oe, pin_do, ack_done, ovl_err} == 4'b0, "R12", "outputs in reset", {pin_oe, pin_do, ack_done, ovl_err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({pin_oe, pin_do, ack_done, ovl_err} == 4'b0, "R12", "outputs after reset", {pin_oe, pin_do, ack_done, ovl_err}, 0);

        // R1/R2: early completion, pulse at the minimum
        t0 = cyc;
        expect_ack(t0 + 1 + MINC, "R2");
        strobe(0);
        wait_until(t0 + 7);
        check(ser_tick == 1'b0, "R1", "tick before phase end", ser_tick, 0);
        @(negedge clk);
        check(ser_tick == 1'b1, "R1", "first tick after resync", ser_tick, 1);
        @(negedge clk);
        check(ser_tick == 1'b0, "R1", "tick width", ser_tick, 0);
        wait_until(t0 + 16);
        check(ser_tick == 1'b1, "R1", "second tick", ser_tick, 1);
        wait_until(t0 + 20);
        strobe(1);
        wait_until(t0 + 1 + MINC - 1);
        check(pin_oe == 1'b0, "R2", "pin before minimum", pin_oe, 0);
        wait_until(t0 + 1 + MINC + 40);
        check(pin_oe && !pin_do, "R4", "pin low mid pulse", {pin_oe, pin_do}, 2);
        wait_until(t0 + 1 + MINC + LOWC + 4);
        check(pin_oe && pin_do, "R5", "speedup drive", {pin_oe, pin_do}, 3);
        wait_until(t0 + 1 + MINC + LOWC + SPDC + 2);
        check(!pin_oe && !pin_do && !ack_done, "R6", "released, done gone", {pin_oe, pin_do, ack_done}, 0);

        // R3: late completion
        t0 = cyc;
        strobe(0);
        wait_until(t0 + 400);
        check(pin_oe == 1'b0, "R3", "no pulse without completion", pin_oe, 0);
        t1 = cyc;
        expect_ack(t1 + 1, "R3");
        strobe(1);
        wait_until(t1 + 1 + LOWC + SPDC + 4);

        // R7: low-power entry cancels
        t0 = cyc;
        strobe(0);
        wait_until(t0 + 50);
        strobe(2);
        wait_until(t0 + 500);
        check(pin_oe == 1'b0, "R7", "no pulse after cancel", pin_oe, 0);
        strobe(1);
        repeat (10) @(negedge clk);
        check(pin_oe == 1'b0, "R7", "stale completion after cancel", pin_oe, 0);

        // R8: low-power entry after latched completion has no effect
        t0 = cyc;
        expect_ack(t0 + 1 + MINC, "R8");
        strobe(0);
        check(ovl_err == 1'b0, "R7", "new command accepted cleanly", ovl_err, 0);
        wait_until(t0 + 10);
        strobe(1);
        wait_until(t0 + 30);
        strobe(2);
        wait_until(t0 + 1 + MINC + LOWC + SPDC + 4);

        // R9: completion and low-power entry in the same cycle
        t0 = cyc;
        strobe(0);
        wait_until(t0 + 300);
        t1 = cyc;
        expect_ack(t1 + 1, "R9");
        strobe(3);
        wait_until(t1 + 1 + LOWC + SPDC + 4);

        // R10: overlapping command ends
        t0 = cyc;
        expect_ack(t0 + 1 + MINC, "R10");
        strobe(0);
        wait_until(t0 + 10);
        strobe(1);
        wait_until(t0 + 100);
        expect_ev(EV_ERR, cyc + 1, "R10");
        strobe(0);
        wait_until(t0 + 300);
        expect_ev(EV_ERR, cyc + 1, "R10");
        strobe(0);
        wait_until(t0 + 1 + MINC + LOWC + SPDC + 4);
        check(pin_oe == 1'b0, "R10", "no second pulse", pin_oe, 0);

        // R11: completion while idle is ignored
        t0 = cyc;
        strobe(1);
        wait_until(t0 + 300);
        check(pin_oe == 1'b0, "R11", "no pulse from idle completion", pin_oe, 0);
        t0 = cyc;
        strobe(0);
        wait_until(t0 + 400);
        check(pin_oe == 1'b0, "R11", "idle completion not latched", pin_oe, 0);
        t1 = cyc;
        expect_ack(t1 + 1, "R11");
        strobe(1);
        wait_until(t1 + 1 + LOWC + SPDC + 10);

        check(q_kind.size() == 0, "R6", "expected events left over", q_kind.size(), 0);
        summary();
    end

endmodule